// File: doc/BRIEF.md
# Interrupt Source Gate

This block sits at the front of a platform interrupt controller and owns the per-source state for up to a parameterised number of interrupt sources; source 0 is reserved and never exists. Each source has a configuration word that either selects a trigger mode or hands the source over to a child domain. The block passes the wire inputs through a synchronizer, turns them into pending bits according to the selected mode, and keeps one enable bit for each source.

Software reaches the state through a single-cycle write port and a combinational read port. Pending and enable bits can be set or cleared in two ways: as 32-bit bit arrays, where bit i of word w stands for source 32*w+i, or by naming one source number. The pending, enabled and raw-level vectors leave the block as plain outputs. Downstream logic picks the winning source and delivers the interrupt.

Top module: `irq_src_gate`

## Requirements
- R1: A configuration write (op 0, wr_addr = source number) with bit 10 clear stores only bits [2:0] as the mode and zeroes all other bits. Mode codes: 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. A configuration read (op 0, rd_addr = source) returns the stored word, and returns 0 for source 0.
- R2: A configuration write with bit 10 set, when NUM_CHILD > 0, stores bit 10 and the child index in bits [9:0]. No mode is stored, and the source no longer reacts to its input or to software pending and enable requests.
- R3: When NUM_CHILD = 0, a configuration write with bit 10 set stores a word of all zeros.
- R4: A configuration write whose stored result is zero, or has bit 10 set, clears that source's pending and enable bits on the same clock edge.
- R5: Inputs pass through a SYNC_STAGES-flop synchronizer. In rising-edge mode a low-to-high change of the synchronized input sets pending, with pending visible three clock edges after the input changes (default depth 2). A steady high level sets nothing more.
- R6: In falling-edge mode a high-to-low change of the synchronized input sets pending. Inactive and detached sources never take pending from their input.
- R7: In level-high mode pending is set on every cycle the synchronized input is high. In level-low mode it is set on every cycle the input is low.
- R8: lvl_o holds the synchronized input level recorded on the previous cycle. A read of the clear-pending array (op 3) returns these levels.
- R9: Software set-pending and clear-pending requests take effect on detached and edge-mode sources. Array ops are 1 (set) and 3 (clear); number ops are 2 (set) and 4 (clear), with the source number in wr_data. These requests have no effect on inactive, delegated and level-mode sources. A pending array read (op 1) returns the pending bits.
- R10: Software enable requests act on every source that is neither inactive nor delegated. Array ops are 5 (set) and 7 (clear); number ops are 6 (set) and 8 (clear). An enable array read (op 5) returns the enable bits, and a clear-enable array read (op 7) always returns 0.
- R11: In every bit array, bit 0 of word 0 and bits for sources above NUM_SRC are ignored on write and read as 0. Words beyond the last implemented word read as 0, and number writes naming 0 or a source above NUM_SRC change nothing.
- R12: A clear-pending write that takes effect wins over a hardware pending set in the same cycle. This includes a clearing configuration write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt wires, bit s for source s |
| wr_en | input | 1 | Write strobe, one operation per cycle |
| wr_op | input | 4 | Write operation code (0..8) |
| wr_addr | input | AW | Source number (config) or word index (arrays) |
| wr_data | input | 32 | Write data: config word, bit array or source number |
| rd_op | input | 4 | Read operation code |
| rd_addr | input | AW | Source number or word index for reads |
| rd_data | output | 32 | Combinational read data |
| pend_o | output | NUM_SRC | Pending bits, bit s for source s |
| en_o | output | NUM_SRC | Enable bits |
| lvl_o | output | NUM_SRC | Recorded synchronized input levels |

## Verification
Edge modes are driven with a single transition followed by a long steady level. This separates a true edge detector from level sampling, which would fill pending again after a clear. The two level modes are held steady while a clear is attempted, so a design that lets software clear a level source shows up. Array writes use an all-ones word to expose bit 0 and bits above the source count, and the rising-edge case is timed so a clear lands on the very edge where the hardware set arrives, which shows the write priority.

// File: rtl/irq_src_gate_pkg.sv
package irq_src_gate_pkg;

   localparam int CFG_W   = 11;
   localparam int DLG_BIT = 10;
   localparam int CHILD_W = 10;
   localparam int MODE_W  = 3;

   typedef enum logic [3:0] {
      OP_CFG      = 4'd0,
      OP_SETP     = 4'd1,
      OP_SETP_NUM = 4'd2,
      OP_CLRP     = 4'd3,
      OP_CLRP_NUM = 4'd4,
      OP_SETE     = 4'd5,
      OP_SETE_NUM = 4'd6,
      OP_CLRE     = 4'd7,
      OP_CLRE_NUM = 4'd8
   } op_e;

   localparam logic [MODE_W-1:0] M_INACTIVE = 3'd0;
   localparam logic [MODE_W-1:0] M_DETACHED = 3'd1;
   localparam logic [MODE_W-1:0] M_RISE     = 3'd4;
   localparam logic [MODE_W-1:0] M_FALL     = 3'd5;
   localparam logic [MODE_W-1:0] M_HIGH     = 3'd6;
   localparam logic [MODE_W-1:0] M_LOW      = 3'd7;

endpackage

// File: rtl/irq_src_gate_sync.sv
module irq_src_gate_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= st[k-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/irq_src_gate_dec.sv
module irq_src_gate_dec
   import irq_src_gate_pkg::*;
#(
   parameter int NUM_SRC   = 31,
   parameter int NUM_CHILD = 1,
   parameter int AW        = 5
) (
   input  logic              wr_en,
   input  logic [3:0]        wr_op,
   input  logic [AW-1:0]     wr_addr,
   input  logic [31:0]       wr_data,
   output logic [NUM_SRC:1]  cfg_wr,
   output logic [NUM_SRC:1]  set_p,
   output logic [NUM_SRC:1]  clr_p,
   output logic [NUM_SRC:1]  set_e,
   output logic [NUM_SRC:1]  clr_e,
   output logic [CFG_W-1:0]  cfg_new
);

   // Stored form of a configuration write; the variant depends on whether
   // any child domain exists.
   if (NUM_CHILD > 0) begin : g_child
      always_comb begin
         if (wr_data[DLG_BIT]) cfg_new = {1'b1, wr_data[CHILD_W-1:0]};
         else                  cfg_new = {{(CFG_W-MODE_W){1'b0}}, wr_data[MODE_W-1:0]};
      end
   end else begin : g_nochild
      always_comb begin
         if (wr_data[DLG_BIT]) cfg_new = '0;
         else                  cfg_new = {{(CFG_W-MODE_W){1'b0}}, wr_data[MODE_W-1:0]};
      end
   end

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
      localparam logic [AW-1:0] WIDX = AW'(s / 32);
      localparam int            WBIT = s % 32;
      logic arr_hit;
      logic num_hit;
      assign arr_hit = (wr_addr == WIDX) && wr_data[WBIT];
      assign num_hit = (wr_data == 32'(s));

      assign cfg_wr[s] = wr_en && (wr_op == OP_CFG) && (wr_addr == AW'(s));
      assign set_p[s]  = wr_en && (((wr_op == OP_SETP) && arr_hit) ||
                                   ((wr_op == OP_SETP_NUM) && num_hit));
      assign clr_p[s]  = wr_en && (((wr_op == OP_CLRP) && arr_hit) ||
                                   ((wr_op == OP_CLRP_NUM) && num_hit));
      assign set_e[s]  = wr_en && (((wr_op == OP_SETE) && arr_hit) ||
                                   ((wr_op == OP_SETE_NUM) && num_hit));
      assign clr_e[s]  = wr_en && (((wr_op == OP_CLRE) && arr_hit) ||
                                   ((wr_op == OP_CLRE_NUM) && num_hit));
   end

endmodule

// File: rtl/irq_src_gate_slot.sv
module irq_src_gate_slot
   import irq_src_gate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_s,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_new,
   input  logic             set_p,
   input  logic             clr_p,
   input  logic             set_e,
   input  logic             clr_e,
   output logic             pend,
   output logic             en,
   output logic             lvl,
   output logic [CFG_W-1:0] cfg
);

   logic [CFG_W-1:0]  cfg_q;
   logic              lvl_q;
   logic              pend_q;
   logic              en_q;
   logic [MODE_W-1:0] mode;
   logic              dlg;
   logic              hw_hit;
   logic              active;
   logic              is_level;
   logic              sw_p_ok;
   logic              sw_e_ok;
   logic              wipe;

   assign mode = cfg_q[MODE_W-1:0];
   assign dlg  = cfg_q[DLG_BIT];

   always_comb begin
      hw_hit = 1'b0;
      if (!dlg) begin
         unique case (mode)
            M_RISE:  hw_hit = lvl_s && !lvl_q;
            M_FALL:  hw_hit = !lvl_s && lvl_q;
            M_HIGH:  hw_hit = lvl_s;
            M_LOW:   hw_hit = !lvl_s;
            default: hw_hit = 1'b0;
         endcase
      end
   end

   assign active   = !dlg && (mode != M_INACTIVE);
   assign is_level = (mode == M_HIGH) || (mode == M_LOW);
   assign sw_p_ok  = active && !is_level;
   assign sw_e_ok  = active;
   assign wipe     = cfg_wr && (cfg_new[DLG_BIT] || (cfg_new == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         lvl_q <= 1'b0;
      end else begin
         lvl_q <= lvl_s;
         if (cfg_wr) cfg_q <= cfg_new;
      end
   end

   // Clearing writes are evaluated before the hardware set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend_q <= 1'b0;
      else if (wipe)               pend_q <= 1'b0;
      else if (clr_p && sw_p_ok)   pend_q <= 1'b0;
      else if (set_p && sw_p_ok)   pend_q <= 1'b1;
      else if (hw_hit)             pend_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q <= 1'b0;
      else if (wipe)               en_q <= 1'b0;
      else if (clr_e && sw_e_ok)   en_q <= 1'b0;
      else if (set_e && sw_e_ok)   en_q <= 1'b1;
   end

   assign pend = pend_q;
   assign en   = en_q;
   assign lvl  = lvl_q;
   assign cfg  = cfg_q;

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
   import irq_src_gate_pkg::*;
#(
   parameter  int NUM_SRC     = 31,
   parameter  int NUM_CHILD   = 1,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(NUM_SRC + 1),
   localparam int WORDS       = (NUM_SRC + 1 + 31) / 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC:1]  irq_in,
   input  logic              wr_en,
   input  logic [3:0]        wr_op,
   input  logic [AW-1:0]     wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        rd_op,
   input  logic [AW-1:0]     rd_addr,
   output logic [31:0]       rd_data,
   output logic [NUM_SRC:1]  pend_o,
   output logic [NUM_SRC:1]  en_o,
   output logic [NUM_SRC:1]  lvl_o
);

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_src
      $error("irq_src_gate: NUM_SRC must lie in 1..1023");
   end
   if (NUM_CHILD < 0 || NUM_CHILD > 1024) begin : g_bad_child
      $error("irq_src_gate: NUM_CHILD must lie in 0..1024");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_gate: SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC:1]             lvl_s;
   logic [NUM_SRC:1]             cfg_wr;
   logic [NUM_SRC:1]             set_p;
   logic [NUM_SRC:1]             clr_p;
   logic [NUM_SRC:1]             set_e;
   logic [NUM_SRC:1]             clr_e;
   logic [CFG_W-1:0]             cfg_new;
   logic [NUM_SRC:1][CFG_W-1:0]  cfg_q;

   irq_src_gate_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (lvl_s)
   );

   irq_src_gate_dec #(.NUM_SRC(NUM_SRC), .NUM_CHILD(NUM_CHILD), .AW(AW)) u_dec (
      .wr_en   (wr_en),
      .wr_op   (wr_op),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg_wr  (cfg_wr),
      .set_p   (set_p),
      .clr_p   (clr_p),
      .set_e   (set_e),
      .clr_e   (clr_e),
      .cfg_new (cfg_new)
   );

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_slot
      irq_src_gate_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_s   (lvl_s[s]),
         .cfg_wr  (cfg_wr[s]),
         .cfg_new (cfg_new),
         .set_p   (set_p[s]),
         .clr_p   (clr_p[s]),
         .set_e   (set_e[s]),
         .clr_e   (clr_e[s]),
         .pend    (pend_o[s]),
         .en      (en_o[s]),
         .lvl     (lvl_o[s]),
         .cfg     (cfg_q[s])
      );
   end

   // Bit arrays padded to whole words; position 0 and the tail read as zero.
   logic [WORDS*32-1:0] pend_pad;
   logic [WORDS*32-1:0] en_pad;
   logic [WORDS*32-1:0] lvl_pad;

   always_comb begin
      pend_pad = '0;
      en_pad   = '0;
      lvl_pad  = '0;
      pend_pad[NUM_SRC:1] = pend_o;
      en_pad[NUM_SRC:1]   = en_o;
      lvl_pad[NUM_SRC:1]  = lvl_o;
   end

   logic [31:0] cfg_word;
   logic [31:0] pend_word;
   logic [31:0] en_word;
   logic [31:0] lvl_word;

   always_comb begin
      cfg_word = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (rd_addr == AW'(s)) cfg_word = {{(32-CFG_W){1'b0}}, cfg_q[s]};
      end
   end

   always_comb begin
      pend_word = '0;
      en_word   = '0;
      lvl_word  = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (rd_addr == AW'(w)) begin
            pend_word = pend_pad[w*32 +: 32];
            en_word   = en_pad[w*32 +: 32];
            lvl_word  = lvl_pad[w*32 +: 32];
         end
      end
   end

   always_comb begin
      unique case (rd_op)
         OP_CFG:  rd_data = cfg_word;
         OP_SETP: rd_data = pend_word;
         OP_CLRP: rd_data = lvl_word;
         OP_SETE: rd_data = en_word;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_src_gate_chk.sv
module irq_src_gate_chk
   import irq_src_gate_pkg::*;
#(
   parameter  int NUM_SRC = 31,
   localparam int AW      = $clog2(NUM_SRC + 1)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [3:0]                 wr_op,
   input logic [AW-1:0]              wr_addr,
   input logic [31:0]                wr_data,
   input logic [3:0]                 rd_op,
   input logic [31:0]                rd_data,
   input logic [NUM_SRC:1]           pend_o,
   input logic [NUM_SRC:1]           en_o,
   input logic [NUM_SRC:1][CFG_W-1:0] cfg_q
);

   a_r10_clre_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_op == OP_CLRE) |-> (rd_data == 32'd0));

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
      a_r4_cfg_wipe: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_op == OP_CFG && wr_addr == AW'(s) &&
          (wr_data[DLG_BIT] || wr_data[MODE_W-1:0] == 3'd0))
         |=> (!pend_o[s] && !en_o[s]));

      a_r10_en_by_write: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en_o[s]) |-> $past(wr_en));

      a_r9_inactive_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_o[s]) |-> ($past(cfg_q[s]) != '0));

      a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_op == OP_CLRP_NUM && wr_data == 32'(s) &&
          !cfg_q[s][DLG_BIT] && cfg_q[s][2:1] == 2'b10)
         |=> !pend_o[s]);
   end

endmodule

bind irq_src_gate irq_src_gate_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_op   (wr_op),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_op   (rd_op),
   .rd_data (rd_data),
   .pend_o  (pend_o),
   .en_o    (en_o),
   .cfg_q   (cfg_q)
);

// File: tb/irq_src_gate_bench.sv
module irq_src_gate_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 20;
   localparam int AW         = $clog2(NSRC + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC:1]   irq_in = '0;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_op = '0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [3:0]      rd_op = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [31:0]     rd_data;
   logic [NSRC:1]   pend_o, en_o, lvl_o;

   // second instance without child domains
   logic [NSRC:1]   n_irq = '0;
   logic            n_wr_en = 1'b0;
   logic [3:0]      n_wr_op = '0;
   logic [AW-1:0]   n_wr_addr = '0;
   logic [31:0]     n_wr_data = '0;
   logic [3:0]      n_rd_op = '0;
   logic [AW-1:0]   n_rd_addr = '0;
   logic [31:0]     n_rd_data;
   logic [NSRC:1]   n_pend, n_en, n_lvl;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_src_gate #(.NUM_SRC(NSRC), .NUM_CHILD(2)) u_irq_src_gate (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_op(rd_op), .rd_addr(rd_addr), .rd_data(rd_data),
      .pend_o(pend_o), .en_o(en_o), .lvl_o(lvl_o)
   );

   irq_src_gate #(.NUM_SRC(NSRC), .NUM_CHILD(0)) u_irq_src_gate_nc (
      .clk(clk), .rst_n(rst_n), .irq_in(n_irq),
      .wr_en(n_wr_en), .wr_op(n_wr_op), .wr_addr(n_wr_addr), .wr_data(n_wr_data),
      .rd_op(n_rd_op), .rd_addr(n_rd_addr), .rd_data(n_rd_data),
      .pend_o(n_pend), .en_o(n_en), .lvl_o(n_lvl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] op, input int addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_op = op; wr_addr = AW'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] op, input int addr, output logic [31:0] data);
      rd_op = op; rd_addr = AW'(addr);
      #1 data = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 reset pend", 32'(pend_o), 0);
      chk("R1 reset en", 32'(en_o), 0);
      chk("R8 reset lvl", 32'(lvl_o), 0);
      rd(4'd0, 3, v); chk("R1 reset cfg", v, 0);
   endtask

   task automatic t_bounds();
      logic [31:0] v;
      for (int s = 1; s <= NSRC; s++) wr(4'd0, s, 32'd1);
      wr(4'd1, 0, 32'hFFFF_FFFF);
      v = ((32'd1 << (NSRC + 1)) - 1) & ~32'd1;
      chk("R11 array set range", 32'(pend_o), v >> 1);
      begin logic [31:0] r; rd(4'd1, 0, r); chk("R11 pend array read", r, v); end
      wr(4'd3, 0, 32'hFFFF_FFFF);
      chk("R9 array clear", 32'(pend_o), 0);
      wr(4'd2, 0, 32'd0);
      wr(4'd2, 0, 32'd21);
      wr(4'd1, 1, 32'hFFFF_FFFF);
      chk("R11 src0, beyond count and word1 ignored", 32'(pend_o), 0);
      rd(4'd1, 1, v); chk("R11 word beyond end reads 0", v, 0);
   endtask

   task automatic t_cfg();
      logic [31:0] v;
      wr(4'd0, 1, 32'hFFFF_FBFC);
      rd(4'd0, 1, v); chk("R1 mode only stored", v, 32'h4);
      wr(4'd0, 2, 32'h0000_0FC3);
      rd(4'd0, 2, v); chk("R2 delegate with child idx", v, 32'h7C3);
      @(negedge clk);
      n_wr_en = 1'b1; n_wr_op = 4'd0; n_wr_addr = AW'(1); n_wr_data = 32'h405;
      @(negedge clk);
      n_wr_en = 1'b0; n_rd_op = 4'd0; n_rd_addr = AW'(1);
      #1 chk("R3 delegate without child zeroes", n_rd_data, 0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(4'd0, 1, 32'd4);
      wr(4'd0, 2, 32'd5);
      irq_in[1] = 1'b1; irq_in[2] = 1'b1;
      idle(5);
      chk("R5 rising sets pend", 32'(pend_o[1]), 1);
      chk("R6 fall not on rise", 32'(pend_o[2]), 0);
      rd(4'd3, 0, v); chk("R8 raw levels read", v, 32'h6);
      chk("R8 lvl_o", 32'(lvl_o[2:1]), 32'h3);
      irq_in[2] = 1'b0;
      idle(5);
      chk("R6 falling sets pend", 32'(pend_o[2]), 1);
      wr(4'd3, 0, 32'h6);
      idle(4);
      chk("R5 steady high no re-pend", 32'(pend_o[2:1]), 0);
      irq_in[1] = 1'b0;
      wr(4'd0, 12, 32'd0);
      wr(4'd0, 13, 32'd1);
      irq_in[12] = 1'b1; irq_in[13] = 1'b1;
      idle(5);
      chk("R6 inactive/detached ignore input", 32'(pend_o[13:12]), 0);
   endtask

   task automatic t_level();
      wr(4'd0, 3, 32'd6);
      wr(4'd0, 4, 32'd7);
      wr(4'd0, 5, 32'd6);
      idle(2);
      chk("R7 level low pends on low", 32'(pend_o[4]), 1);
      chk("R7 level high idle", 32'(pend_o[3]), 0);
      irq_in[3] = 1'b1;
      idle(5);
      chk("R7 level high pends", 32'(pend_o[3]), 1);
      wr(4'd4, 0, 32'd3);
      wr(4'd3, 0, 32'h10);
      idle(1);
      chk("R9 clear ignored on level", 32'(pend_o[4:3]), 32'h3);
      wr(4'd2, 0, 32'd5);
      chk("R9 set ignored on level", 32'(pend_o[5]), 0);
   endtask

   task automatic t_sw();
      logic [31:0] v;
      wr(4'd0, 6, 32'd1);
      wr(4'd0, 7, 32'd0);
      wr(4'd0, 8, 32'h401);
      wr(4'd2, 0, 32'd6);
      chk("R9 set by number", 32'(pend_o[6]), 1);
      wr(4'd4, 0, 32'd6);
      chk("R9 clear by number", 32'(pend_o[6]), 0);
      wr(4'd2, 0, 32'd7);
      wr(4'd1, 0, 32'h100);
      chk("R9 ignored inactive/delegated", 32'(pend_o[8:7]), 0);
      wr(4'd6, 0, 32'd7);
      wr(4'd5, 0, 32'h100);
      chk("R10 enable ignored inactive/delegated", 32'(en_o[8:7]), 0);
      wr(4'd5, 0, 32'h40);
      chk("R10 enable by array", 32'(en_o[6]), 1);
      rd(4'd5, 0, v); chk("R10 enable array read", v & 32'h1C0, 32'h40);
      rd(4'd7, 0, v); chk("R10 clear-enable reads 0", v, 0);
      wr(4'd8, 0, 32'd6);
      chk("R10 clear enable by number", 32'(en_o[6]), 0);
   endtask

   task automatic t_wipe();
      wr(4'd0, 9, 32'd1);
      wr(4'd0, 10, 32'd1);
      wr(4'd1, 0, 32'h600);
      wr(4'd5, 0, 32'h600);
      chk("R4 setup", 32'(pend_o[10:9] & en_o[10:9]), 32'h3);
      wr(4'd0, 9, 32'd0);
      chk("R4 zero cfg clears", 32'({pend_o[9], en_o[9]}), 0);
      wr(4'd0, 10, 32'h402);
      chk("R4 delegate cfg clears", 32'({pend_o[10], en_o[10]}), 0);
   endtask

   task automatic t_prio();
      wr(4'd0, 11, 32'd4);
      @(negedge clk);
      irq_in[11] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_op = 4'd4; wr_data = 32'd11;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R12 clear beats edge set", 32'(pend_o[11]), 0);
      idle(3);
      chk("R12 stays clear", 32'(pend_o[11]), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bounds();
      t_cfg();
      t_edge();
      t_level();
      t_sw();
      t_wipe();
      t_prio();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule